// File: doc/BRIEF.md
# Serial Divider Configuration Register

This block keeps the active divider and test-select settings for a clock synthesizer. A 12-bit configuration word arrives one bit at a time on a slow serial clock and collects in a shift register. A rising edge on a separate load strobe then copies the word into the active registers. A low-active pin-mode control lets board pins set the feedback divider (M, 7 bits) and the post divider (N, 2 bits) directly, which is the usual way to bring the part up. While pin mode is active, the test-select field (T, 3 bits) is held at its quiet value of zero.

All three serial inputs are slow compared with the system clock. Each one passes through a two-stage synchronizer, and the edges that matter are detected in the system clock domain. The bit at the top of the shift register drives a serial output so that test equipment can watch the stream. The PLL, the dividers themselves and the output drivers are not part of this block.

Top module: `cfg_serial_loader`

## Requirements
- R1: A synchronous active-high reset clears the shift register, the serial output and T to zero, and sets M to 40 and N to 1.
- R2: On each synchronized rising edge of `sr_clk`, the shift register moves one place toward its MSB and takes `sr_data` into bit 0. No other input changes it.
- R3: The word is 12 bits wide and T2 is sent first. After a full frame the word holds T in bits 11:9, N in bits 8:7 and M in bits 6:0.
- R4: When `pin_cfg_n` is high, a rising edge of `sr_strobe` copies the three fields of the shift register into `div_m`, `div_n` and `tsel`.
- R5: When `pin_cfg_n` is low, `div_m` and `div_n` follow `pin_m` and `pin_n` one clock later, and `tsel` is 000.
- R6: A strobe edge while `pin_cfg_n` is low has no effect. T stays 000 and M and N stay at the pin values.
- R7: When `pin_cfg_n` is high and no strobe edge occurs, the outputs hold their values, including while bits are being shifted in.
- R8: `sr_out` always equals the MSB of the shift register, so after a full frame it shows the first bit of that frame.
- R9: Only the rising edge of the strobe loads the outputs. A strobe held high while a new frame is shifted in leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sr_clk | input | 1 | Serial bit clock (asynchronous, slow) |
| sr_data | input | 1 | Serial data bit |
| sr_strobe | input | 1 | Load strobe; its rising edge copies the word |
| pin_cfg_n | input | 1 | Low: the pins drive M and N, and T is forced to 0 |
| pin_m | input | 7 | Parallel M value |
| pin_n | input | 2 | Parallel N value |
| div_m | output | 7 | Active M divider value |
| div_n | output | 2 | Active N divider value |
| tsel | output | 3 | Active test-select value |
| sr_out | output | 1 | MSB of the shift register |

## Verification
A corrupted shift register is visible on `sr_out` after the next synchronized serial clock edge. It also appears on all three outputs at the next strobe, which is where field misplacement or bit-order reversal shows up. Faults in the active registers appear within one system clock of the event that caused them: a spurious update during shifting, a strobe that gets through in pin mode, or a test field that is not forced to zero. The checks therefore compare outputs just before and just after each strobe and each change of pin mode.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_M_W = 7;
  localparam int CFG_N_W = 2;
  localparam int CFG_T_W = 3;
  localparam int CFG_SYNC_STAGES = 2;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              last;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
          last  <= 1'b0;
        end else begin
          chain <= {chain[STAGES-2:0], din[gi]};
          last  <= chain[STAGES-1];
        end
      end
      assign lvl[gi]  = chain[STAGES-1];
      assign rise[gi] = chain[STAGES-1] & ~last;

      // R9: an edge pulse lasts one cycle only
      a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise[gi] |=> !rise[gi]);
    end
  endgenerate
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         sout
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end

  assign sout = q[W-1];

  // R2: shifting moves every bit one place up
  a_r2_shift_up: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (q[W-1:1] == $past(q[W-2:0])));
  // R2: without an edge the register is untouched
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/cfg_active.sv
module cfg_active #(
  parameter int           M_W   = 7,
  parameter int           N_W   = 2,
  parameter int           T_W   = 3,
  parameter logic [M_W-1:0] M_RST = 40,
  parameter logic [N_W-1:0] N_RST = 1,
  localparam int          FW    = M_W + N_W + T_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pin_mode,
  input  logic [M_W-1:0] pin_m,
  input  logic [N_W-1:0] pin_n,
  input  logic           load,
  input  logic [FW-1:0]  frame,
  output logic [M_W-1:0] div_m,
  output logic [N_W-1:0] div_n,
  output logic [T_W-1:0] tsel
);
  logic [M_W-1:0] f_m;
  logic [N_W-1:0] f_n;
  logic [T_W-1:0] f_t;

  assign f_t = frame[FW-1 -: T_W];
  assign f_n = frame[M_W +: N_W];
  assign f_m = frame[M_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_m <= M_RST;
      div_n <= N_RST;
      tsel  <= '0;
    end else if (pin_mode) begin
      div_m <= pin_m;
      div_n <= pin_n;
      tsel  <= '0;
    end else if (load) begin
      div_m <= f_m;
      div_n <= f_n;
      tsel  <= f_t;
    end
  end

  // R5: pin mode keeps the test field quiet
  a_r5_tsel_quiet: assert property (@(posedge clk) disable iff (rst)
    pin_mode |=> (tsel == '0));
  // R6: pin mode takes M from the pins even on a strobe
  a_r6_pins_win: assert property (@(posedge clk) disable iff (rst)
    (pin_mode && load) |=> (div_m == $past(pin_m)));
  // R4: strobe copies the test field from the frame
  a_r4_copy_t: assert property (@(posedge clk) disable iff (rst)
    (!pin_mode && load) |=> (tsel == $past(frame[FW-1 -: T_W])));
  // R7: hold between loads
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!pin_mode && !load) |=> $stable({div_m, div_n, tsel}));
  // R1: reset values
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (tsel == '0 && div_m == M_RST && div_n == N_RST));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_pkg::*;
#(
  parameter int             M_W    = CFG_M_W,
  parameter int             N_W    = CFG_N_W,
  parameter int             T_W    = CFG_T_W,
  parameter int             STAGES = CFG_SYNC_STAGES,
  parameter logic [M_W-1:0] M_RST  = 40,
  parameter logic [N_W-1:0] N_RST  = 1,
  localparam int            FW     = M_W + N_W + T_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sr_clk,
  input  logic           sr_data,
  input  logic           sr_strobe,
  input  logic           pin_cfg_n,
  input  logic [M_W-1:0] pin_m,
  input  logic [N_W-1:0] pin_n,
  output logic [M_W-1:0] div_m,
  output logic [N_W-1:0] div_n,
  output logic [T_W-1:0] tsel,
  output logic           sr_out
);
  logic [2:0]    s_lvl, s_rise;
  logic [FW-1:0] word;

  cfg_sync_edge #(.W(3), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .din({sr_strobe, sr_data, sr_clk}),
    .lvl(s_lvl), .rise(s_rise)
  );

  cfg_shift #(.W(FW)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en(s_rise[0]), .din(s_lvl[1]),
    .q(word), .sout(sr_out)
  );

  cfg_active #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .M_RST(M_RST), .N_RST(N_RST)) u_act (
    .clk(clk), .rst(rst),
    .pin_mode(~pin_cfg_n), .pin_m(pin_m), .pin_n(pin_n),
    .load(s_rise[2]), .frame(word),
    .div_m(div_m), .div_n(div_n), .tsel(tsel)
  );

  // R8: serial output reflects the top of the word after each shift
  a_r8_sout_top: assert property (@(posedge clk) disable iff (rst)
    s_rise[0] |=> (sr_out == $past(word[FW-2])));
endmodule

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
  logic clk = 0, rst = 1;
  logic sr_clk = 0, sr_data = 0, sr_strobe = 0, pin_cfg_n = 1;
  logic [6:0] pin_m = 0;
  logic [1:0] pin_n = 0;
  logic [6:0] div_m;
  logic [1:0] div_n;
  logic [2:0] tsel;
  logic sr_out;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  string       tag_q[$];
  event        chk_ev;

  always #5 clk = ~clk;

  cfg_serial_loader dut (
    .clk(clk), .rst(rst), .sr_clk(sr_clk), .sr_data(sr_data),
    .sr_strobe(sr_strobe), .pin_cfg_n(pin_cfg_n), .pin_m(pin_m), .pin_n(pin_n),
    .div_m(div_m), .div_n(div_n), .tsel(tsel), .sr_out(sr_out)
  );

  // monitor: pop expected {T,N,M} and compare
  initial forever begin
    @(chk_ev);
    @(negedge clk);
    while (exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({tsel, div_n, div_m} !== e) begin
        errors++;
        $display("FAIL %s: got T=%b N=%0d M=%0d expected T=%b N=%0d M=%0d",
                 t, tsel, div_n, div_m, e[11:9], e[8:7], e[6:0]);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_cfg(input logic [11:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->chk_ev;
    wait_cyc(2);
  endtask

  task automatic check_sout(input logic e, input string t);
    checks++;
    if (sr_out !== e) begin
      errors++;
      $display("FAIL %s: sr_out=%b expected %b", t, sr_out, e);
    end
  endtask

  task automatic shift_bit(input logic b);
    sr_data = b;
    wait_cyc(5);
    sr_clk = 1;
    wait_cyc(5);
    sr_clk = 0;
    wait_cyc(5);
  endtask

  task automatic send_frame(input logic [11:0] f);
    for (int i = 11; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic strobe();
    sr_strobe = 1;
    wait_cyc(6);
    sr_strobe = 0;
    wait_cyc(6);
  endtask

  localparam logic [11:0] F1 = {3'b101, 2'b10, 7'h2A};
  localparam logic [11:0] F2 = {3'b110, 2'b01, 7'h55};
  localparam logic [11:0] F3 = {3'b011, 2'b11, 7'h7F};
  localparam logic [11:0] F4 = {3'b000, 2'b00, 7'h01};
  localparam logic [11:0] RST_V = {3'b000, 2'd1, 7'd40};

  initial begin
    wait_cyc(4);
    expect_cfg(RST_V, "R1 reset values");
    check_sout(1'b0, "R1 serial out after reset");
    rst = 0;
    wait_cyc(3);

    send_frame(F1);
    expect_cfg(RST_V, "R7 outputs held while shifting");
    check_sout(F1[11], "R8 first bit on serial out");
    strobe();
    expect_cfg(F1, "R3 R4 frame fields after strobe");

    shift_bit(1'b1);
    check_sout(F1[10], "R2 one extra shift");
    expect_cfg(F1, "R7 hold after extra shift");

    send_frame(F2);
    expect_cfg(F1, "R7 hold before strobe");
    strobe();
    expect_cfg(F2, "R4 second frame");

    send_frame(F3);
    sr_strobe = 1;
    wait_cyc(6);
    expect_cfg(F3, "R4 third frame on rise");
    send_frame(F4);
    expect_cfg(F3, "R9 held strobe ignores new frame");
    sr_strobe = 0;
    wait_cyc(6);
    expect_cfg(F3, "R9 falling strobe no load");

    pin_m = 7'h12; pin_n = 2'd3; pin_cfg_n = 0;
    wait_cyc(2);
    expect_cfg({3'b000, 2'd3, 7'h12}, "R5 pin mode values");
    strobe();
    expect_cfg({3'b000, 2'd3, 7'h12}, "R6 strobe ignored in pin mode");
    pin_m = 7'h09; pin_n = 2'd2;
    wait_cyc(2);
    expect_cfg({3'b000, 2'd2, 7'h09}, "R5 pins followed");
    pin_cfg_n = 1;
    wait_cyc(3);
    expect_cfg({3'b000, 2'd2, 7'h09}, "R7 hold after leaving pin mode");
    send_frame(F2);
    strobe();
    expect_cfg(F2, "R4 serial overrides after pin mode");
    check_sout(F2[11], "R8 serial out after frame");

    rst = 1;
    wait_cyc(3);
    expect_cfg(RST_V, "R1 reset mid run");
    check_sout(1'b0, "R1 serial out cleared");
    rst = 0;
    wait_cyc(4);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule